// File: doc/BRIEF.md
# Exception-Return Status Register Shifter

This block produces the processor status word and stack pointers that take effect when a return-from-exception or a return-from-NMI instruction retires. On that instruction the saved flag levels held higher in the status word are popped down into the active low field by a right shift. The two most significant bits stay where they are. The privilege and NMI-mask flags are then forced according to the kind of return.

When the popped status selects user mode, the active stack pointer is parked in the kernel stack pointer register and the user stack pointer becomes active. The surrounding pipeline presents the current status and the three stack pointer values together with a one-cycle retire strobe and a kind bit. Everything the block produces is registered and changes only on a strobed edge.

Top module: `exret_status_unit`

## Requirements
- R1: On a strobed edge, bits 31:30 of the new status equal bits 31:30 of `status_in`.
- R2: On a strobed edge, bits 29:18 of the new status are zero.
- R3: On a strobed edge, new status bits 17:0 equal `status_in[27:10]`, except for bits 7 (P) and 11 (M) when R4 or R5 forces them.
- R4: The R flag is tested at `status_in[9]`, before the shift. If it is clear, new status bit 7 (P) is 1. If it is set, bit 7 carries `status_in[17]` unchanged.
- R5: When `ret_nmi` is 1 (NMI return), new status bit 11 (M) is 1. When `ret_nmi` is 0 (exception return), bit 11 carries `status_in[21]`.
- R6: When new status bit 8 (U) is 1, `ksp_out` takes the old `sp_in` and `sp_out` takes `usp_in`.
- R7: When new status bit 8 (U) is 0, `sp_out` takes `sp_in` and `ksp_out` takes `ksp_in`.
- R8: While `ret_valid` is 0, all three outputs hold their values whatever the other inputs do.
- R9: A synchronous reset (`rst` high at a clock edge) clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Return instruction retires this cycle |
| ret_nmi | input | 1 | 1 = NMI return, 0 = exception return |
| status_in | input | 32 | Status word before the return |
| sp_in | input | 32 | Active stack pointer |
| usp_in | input | 32 | User stack pointer register |
| ksp_in | input | 32 | Kernel stack pointer register |
| status_out | output | 32 | Registered status after the return |
| sp_out | output | 32 | Registered active stack pointer |
| ksp_out | output | 32 | Registered kernel stack pointer |

## Verification
On every cycle, the assertions check four things:
- the top-bit carry and the cleared middle bits;
- the forcing of P and M from the pre-shift R flag and the return kind;
- the choice between swapping and keeping the stacks, keyed on the registered U bit;
- holding of the outputs while no strobe is present.

The exact placement of the popped low field only shows up in the bench's sweep. So does the pass-through of P and M when they are not forced. The sweep crosses both return kinds with R set and clear and with user and kernel results, over varied data words. Recovery from reset is likewise shown only by the bench.

// File: rtl/exret_pkg.sv
package exret_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned KEEP_W  = 2;
  localparam int unsigned GAP_W   = 2;
  localparam int unsigned POP_SH  = 10;
  localparam int unsigned P_POS   = 7;
  localparam int unsigned U_POS   = 8;
  localparam int unsigned R_POS   = 9;
  localparam int unsigned M_POS   = 11;

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/exret_field_pop.sv
module exret_field_pop
  import exret_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned KEEP  = KEEP_W,
  parameter int unsigned GAP   = GAP_W,
  parameter int unsigned SH    = POP_SH,
  parameter int unsigned P_BIT = P_POS,
  parameter int unsigned R_BIT = R_POS,
  parameter int unsigned M_BIT = M_POS
) (
  input  logic [W-1:0] st_i,
  input  ret_kind_e    kind_i,
  output logic [W-1:0] st_o
);
  localparam logic [W-1:0] ONES     = {W{1'b1}};
  localparam logic [W-1:0] TOP_MASK = ~(ONES >> KEEP);
  localparam logic [W-1:0] LOW_MASK = ONES >> (KEEP + GAP);

  logic [W-1:0] popped;

  always_comb begin
    popped = ((st_i & LOW_MASK) >> SH) | (st_i & TOP_MASK);
    st_o   = popped;
    if (!st_i[R_BIT]) st_o[P_BIT] = 1'b1;
    if (kind_i == RET_NMI) st_o[M_BIT] = 1'b1;
  end
endmodule

// File: rtl/exret_stack_sel.sv
module exret_stack_sel #(
  parameter int unsigned W = 32
) (
  input  logic         user_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  input  logic [W-1:0] ksp_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ksp_o
);
  always_comb begin
    if (user_i) begin
      ksp_o = sp_i;
      sp_o  = usp_i;
    end else begin
      ksp_o = ksp_i;
      sp_o  = sp_i;
    end
  end
endmodule

// File: rtl/exret_status_unit.sv
module exret_status_unit
  import exret_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned KEEP  = KEEP_W,
  parameter int unsigned GAP   = GAP_W,
  parameter int unsigned SH    = POP_SH,
  parameter int unsigned P_BIT = P_POS,
  parameter int unsigned U_BIT = U_POS,
  parameter int unsigned R_BIT = R_POS,
  parameter int unsigned M_BIT = M_POS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ret_valid,
  input  logic         ret_nmi,
  input  logic [W-1:0] status_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] usp_in,
  input  logic [W-1:0] ksp_in,
  output logic [W-1:0] status_out,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] ksp_out
);
  localparam int unsigned GAP_HI = W - KEEP - 1;
  localparam int unsigned GAP_LO = W - KEEP - GAP - SH;

  ret_kind_e    kind;
  logic [W-1:0] st_next;
  logic [W-1:0] sp_next;
  logic [W-1:0] ksp_next;

  assign kind = ret_nmi ? RET_NMI : RET_EXC;

  exret_field_pop #(
    .W(W), .KEEP(KEEP), .GAP(GAP), .SH(SH),
    .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
  ) u_pop (
    .st_i  (status_in),
    .kind_i(kind),
    .st_o  (st_next)
  );

  exret_stack_sel #(.W(W)) u_stk (
    .user_i(st_next[U_BIT]),
    .sp_i  (sp_in),
    .usp_i (usp_in),
    .ksp_i (ksp_in),
    .sp_o  (sp_next),
    .ksp_o (ksp_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_out <= '0;
      sp_out     <= '0;
      ksp_out    <= '0;
    end else if (ret_valid) begin
      status_out <= st_next;
      sp_out     <= sp_next;
      ksp_out    <= ksp_next;
    end
  end

  // R1
  top_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> status_out[W-1 -: KEEP] == $past(status_in[W-1 -: KEEP]));

  // R2
  gap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> status_out[GAP_HI:GAP_LO] == '0);

  // R4
  p_force_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !status_in[R_BIT]) |=> status_out[P_BIT]);

  // R5
  m_force_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_nmi) |=> status_out[M_BIT]);

  // R6
  user_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid ##1 status_out[U_BIT]) |->
      (sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

  // R7
  kern_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid ##1 !status_out[U_BIT]) |->
      (sp_out == $past(sp_in) && ksp_out == $past(ksp_in)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> ($stable(status_out) && $stable(sp_out) && $stable(ksp_out)));
endmodule

// File: tb/exret_status_unit_tb.sv
`timescale 1ns/1ps
module exret_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ret_valid = 1'b0;
  logic        ret_nmi = 1'b0;
  logic [31:0] status_in = '0, sp_in = '0, usp_in = '0, ksp_in = '0;
  logic [31:0] status_out, sp_out, ksp_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  exret_status_unit u_dut (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_nmi(ret_nmi),
    .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in), .ksp_in(ksp_in),
    .status_out(status_out), .sp_out(sp_out), .ksp_out(ksp_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] exp_st, exp_sp, exp_ksp, s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 status", status_out, 32'h0);
    check("R9 sp", sp_out, 32'h0);
    check("R9 ksp", ksp_out, 32'h0);

    for (int combo = 0; combo < 8; combo++) begin
      for (int v = 0; v < 8; v++) begin
        s = next_rand();
        s[9]  = combo[0];
        s[18] = combo[1];
        status_in = s;
        ret_nmi   = combo[2];
        sp_in     = next_rand();
        usp_in    = next_rand();
        ksp_in    = next_rand();
        ret_valid = 1'b1;
        exp_st = {s[31:30], 12'h000, s[27:10]};
        if (!s[9]) exp_st[7] = 1'b1;
        if (combo[2]) exp_st[11] = 1'b1;
        if (exp_st[8]) begin
          exp_sp = usp_in; exp_ksp = sp_in;
        end else begin
          exp_sp = sp_in; exp_ksp = ksp_in;
        end
        @(negedge clk);
        ret_valid = 1'b0;
        check("R1", {30'h0, status_out[31:30]}, {30'h0, exp_st[31:30]});
        check("R2", {20'h0, status_out[29:18]}, 32'h0);
        check("R3", status_out & ~32'h0000_0880, exp_st & ~32'h0000_0880);
        check("R4", {31'h0, status_out[7]}, {31'h0, s[9] ? s[17] : 1'b1});
        check("R5", {31'h0, status_out[11]}, {31'h0, combo[2] ? 1'b1 : s[21]});
        if (exp_st[8]) begin
          check("R6 sp", sp_out, exp_sp);
          check("R6 ksp", ksp_out, exp_ksp);
        end else begin
          check("R7 sp", sp_out, exp_sp);
          check("R7 ksp", ksp_out, exp_ksp);
        end
        // R8 no strobe: change inputs and confirm outputs hold
        status_in = ~s; ret_nmi = ~ret_nmi;
        sp_in = next_rand(); usp_in = next_rand(); ksp_in = next_rand();
        @(negedge clk);
        check("R8 status", status_out, exp_st);
        check("R8 sp", sp_out, exp_sp);
        check("R8 ksp", ksp_out, exp_ksp);
      end
    end

    // R9 reset from a non-zero state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 status", status_out, 32'h0);
    check("R9 sp", sp_out, 32'h0);
    check("R9 ksp", ksp_out, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule